// File: doc/BRIEF.md
# Programmable UART Frame Transmitter

This block is the serial transmit half of a UART. A byte arrives on a valid/ready stream input. The block then shifts it onto a single output line as one asynchronous frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Timing comes from an external enable pulse that runs at sixteen times the bit rate. Each bit on the line lasts sixteen of those pulses, no matter how many clock cycles lie between them.

Four plain configuration inputs set the word length, parity on or off, parity sense and the number of stop bits. A frame can therefore be 7 to 12 bits long. The block captures the configuration and the byte in the same cycle that it accepts the handshake. Changes made to these inputs while a frame is on the line apply only to later frames.

Back-pressure rules: `in_ready` is high only while the line is idle. A transfer takes place on a rising clock edge where both `in_valid` and `in_ready` are high. Once a byte is taken, `in_ready` stays low until the last stop bit has finished. A source may hold `in_valid` high for the whole frame. Its data is not taken until `in_ready` returns. This allows back-to-back frames with no idle bit between them.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `txd` is 1 and `in_ready` is 1. A reset in the middle of a frame abandons that frame.
- R2: On a rising edge with `in_valid` and `in_ready` both high, the byte is accepted. From the next cycle `in_ready` is 0 and `txd` is 0, which is the start bit.
- R3: Each frame bit is held on `txd` for exactly 16 clock edges at which `tick16` is high. Cycles with `tick16` low neither advance nor change the line.
- R4: Data bits follow the start bit LSB first. Their count is set by `cfg_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Byte bits above that count are not sent.
- R5: With `cfg_par_en` = 1, one parity bit comes straight after the last data bit. With `cfg_par_odd` = 0 it is the XOR of the data bits sent (even parity). With `cfg_par_odd` = 1 it is the inverse of that value.
- R6: One stop bit (`cfg_stop2` = 0) or two stop bits (`cfg_stop2` = 1) follow, each at 1. The whole frame is therefore 7 to 12 bit times.
- R7: The configuration and data are captured at acceptance. Changes to `cfg_*` or `in_data` during a frame do not alter that frame.
- R8: With no frame in progress `txd` stays 1 whatever `tick16` does. `in_valid` asserted while `in_ready` is 0 is not accepted.
- R9: `in_ready` returns to 1 in the cycle after the edge that takes the 16th tick of the last stop bit. A held `in_valid` is accepted at the next edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| in_valid | input | 1 | Source has a byte |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte (line idle) |
| txd | output | 1 | Serial line, idles high |

## Verification
The start bit and the drop of `in_ready` both appear one clock after the accepting edge. The bench checks them at the falling edge right after that edge. Every later bit boundary falls on the edge that consumes the 16th tick pulse of the bit before it. The bench therefore counts the tick pulses it drives itself and samples `txd` at the falling edge after the 8th pulse of each bit, well away from both boundaries. `in_ready` is checked at the falling edge after the final stop-bit tick. At that point a held `in_valid` must cause the start bit of the next frame one clock later.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W        = 8;
  localparam int MIN_W         = 5;
  localparam int LEN_W         = $clog2(DATA_W - MIN_W + 1);
  localparam int TICKS_PER_BIT = 16;
  localparam int IDX_W         = $clog2(DATA_W);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } tx_phase_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             stop2;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign bit_done = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              odd,
  output logic              par
);
  logic [DATA_W-1:0] keep;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < MIN_W) begin : g_always
        assign keep[gi] = data[gi];
      end else begin : g_len
        assign keep[gi] = data[gi] && (int'(len) >= (gi - MIN_W + 1));
      end
    end
  endgenerate

  assign par = (^keep) ^ odd;
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  tx_cfg_t           cfg_in,
  input  logic              par_in,
  output logic              in_ready,
  output logic              txd
);
  localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(MIN_W - 1);

  tx_phase_e         phase;
  tx_cfg_t           cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              par_q;
  logic [IDX_W-1:0]  last_data;
  logic [IDX_W-1:0]  last_stop;

  assign last_data = LAST_BASE + IDX_W'(cfg_q.len);
  assign last_stop = cfg_q.stop2 ? IDX_W'(1) : IDX_W'(0);
  assign in_ready  = (phase == PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = shreg[0];
      PH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cfg_q <= '0;
      shreg <= '0;
      idx   <= '0;
      par_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            phase <= PH_START;
            cfg_q <= cfg_in;
            shreg <= in_data;
            par_q <= par_in;
            idx   <= '0;
          end
        end
        PH_START: begin
          if (bit_done) begin
            phase <= PH_DATA;
            idx   <= '0;
          end
        end
        PH_DATA: begin
          if (bit_done) begin
            shreg <= shreg >> 1;
            if (idx == last_data) begin
              phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_PAR: begin
          if (bit_done) begin
            phase <= PH_STOP;
            idx   <= '0;
          end
        end
        PH_STOP: begin
          if (bit_done) begin
            if (idx == last_stop) begin
              phase <= PH_IDLE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  tx_cfg_t cfg_in;
  logic    par_live;
  logic    bit_done;

  assign cfg_in.len     = cfg_len;
  assign cfg_in.par_en  = cfg_par_en;
  assign cfg_in.par_odd = cfg_par_odd;
  assign cfg_in.stop2   = cfg_stop2;

  uart_tx_parity u_par (
    .data (in_data),
    .len  (cfg_len),
    .odd  (cfg_par_odd),
    .par  (par_live)
  );

  uart_tx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!in_ready),
    .tick     (tick16),
    .bit_done (bit_done)
  );

  uart_tx_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_done (bit_done),
    .in_valid (in_valid),
    .in_data  (in_data),
    .cfg_in   (cfg_in),
    .par_in   (par_live),
    .in_ready (in_ready),
    .txd      (txd)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic txd
);
  logic [7:0] frame_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ticks <= '0;
    end else if (in_valid && in_ready) begin
      frame_ticks <= '0;
    end else if (!in_ready && tick16) begin
      frame_ticks <= frame_ticks + 1'b1;
    end
  end

  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && !in_ready));

  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !in_ready) |=> ($stable(txd) && !in_ready));

  a_r9_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(tick16) && $past(txd)));

  a_r6_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (frame_ticks[3:0] == 4'd0 &&
                         frame_ticks >= 8'd112 && frame_ticks <= 8'd192));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       txd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd)
  );

  // {data[7:0], len[1:0], par_en, par_odd, stop2}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'h3D, 2'd3, 1'b1, 1'b1, 1'b1},
    {8'hFF, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'hE7, 2'd0, 1'b1, 1'b0, 1'b1},
    {8'h5A, 2'd1, 1'b1, 1'b1, 1'b0},
    {8'h81, 2'd2, 1'b1, 1'b0, 1'b1},
    {8'h00, 2'd2, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int gap);
    repeat (gap) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  // Sends one frame; returns with in_valid still high when hold is set.
  task automatic run_frame(input logic [7:0] d, input logic [1:0] l,
                           input logic pe, input logic po, input logic s2,
                           input bit hold);
    logic [11:0] exp_bits;
    int nbits;
    int nd;
    logic par;
    nd = int'(l) + 5;
    par = po;
    for (int i = 0; i < nd; i++) par ^= d[i];
    nbits = 0;
    exp_bits = '0;
    exp_bits[nbits] = 1'b0; nbits++;
    for (int i = 0; i < nd; i++) begin exp_bits[nbits] = d[i]; nbits++; end
    if (pe) begin exp_bits[nbits] = par; nbits++; end
    exp_bits[nbits] = 1'b1; nbits++;
    if (s2) begin exp_bits[nbits] = 1'b1; nbits++; end

    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    @(negedge clk);
    if (!hold) in_valid = 1'b0;
    // R7: scramble everything after acceptance
    in_data = ~d; cfg_len = ~l; cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_stop2 = ~s2;
    chk(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
    chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
    for (int k = 0; k < nbits; k++) begin
      for (int t = 0; t < 16; t++) begin
        pulse((k + t) % 3);
        if (t == 7) begin
          chk(txd == exp_bits[k], $sformatf("R4/R5/R6/R7 bit %0d", k),
              int'(txd), int'(exp_bits[k]));
          chk(in_ready == 1'b0, "R8 busy while frame", int'(in_ready), 0);
          if (k == 1) begin
            repeat (20) @(negedge clk);
            chk(txd == exp_bits[k], "R3 no tick no advance", int'(txd), int'(exp_bits[k]));
          end
        end
      end
    end
    chk(in_ready == 1'b1, "R9 ready after last stop", int'(in_ready), 1);
    chk(txd == 1'b1, "R9 line high at end", int'(txd), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && in_ready == 1'b1, "R1 after release", int'({txd, in_ready}), 3);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);
    end

    // R8: idle with ticks, no valid
    for (int t = 0; t < 40; t++) begin
      pulse(1);
      if (txd != 1'b1 || in_ready != 1'b1)
        chk(1'b0, "R8 idle line", int'({txd, in_ready}), 3);
    end
    chk(txd == 1'b1, "R8 idle stays high", int'(txd), 1);

    // R9/R8: valid held through frame; next byte taken right at ready
    run_frame(8'h96, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 back-to-back accepted", int'(in_ready), 0);
    chk(txd == 1'b0, "R9 back-to-back start", int'(txd), 0);
    in_valid = 1'b0;

    // R1: reset mid-frame
    repeat (5) pulse(0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && in_ready == 1'b1, "R1 reset mid-frame", int'({txd, in_ready}), 3);
    rst_n = 1'b1;
    @(negedge clk);

    // short frame after reset: 5 bits, odd parity, 2 stop (R5/R6)
    run_frame(8'h1F, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule